// File: doc/BRIEF.md
# Rotate-Right Execution Unit

This unit carries out the four forms of an 8-bit rotate-right-by-one instruction in a small CPU core. It takes instruction bytes one at a time from the fetch side. The byte 0xCE acts as a prefix, and a second byte picks the operand: register A, register B, a memory byte addressed through HL, or a memory byte addressed through N plus a displacement byte. The displacement byte follows only in the indexed form.

The operand moves right by one position and its old bit 0 re-enters at bit 7; the carry flag does not take part in the rotation. The unit drives the rotated value back through a write strobe for A, for B or for memory. It also presents a merged flags word in which zero, carry and sign are updated and every other bit is passed through from the flags input. The memory forms perform a read followed by a write to the same 24-bit address, which is bank-extended with register I.

Each form occupies the exact cycle count the core's timing model expects, measured from the prefix byte. The unit marks the end of each instruction with a one-cycle done pulse.

Top module: `rotr_exec_unit`

## Requirements
- R1: While idle, a byte 0xCE with `op_valid` starts decoding. The next valid byte selects the form: 0x9C rotates A, 0x9D rotates B, 0x9E selects the indexed memory form, and 0x9F selects the HL memory form.
- R2: The result is the operand shifted right by one with the old bit 0 placed in bit 7; carry is not an input to the rotation.
- R3: Flag bit 0 (zero) of `flags_out` is 1 exactly when the 8-bit result is 0x00.
- R4: Flag bit 1 (carry) and flag bit 3 (sign) of `flags_out` both equal bit 7 of the result.
- R5: Every `flags_out` bit other than bits 0, 1 and 3, including the overflow flag at bit 2, equals the same bit of `flags_in`.
- R6: Take the cycle in which the prefix byte is presented as cycle 1, with the instruction bytes on consecutive cycles. `done` is then high for exactly one cycle, in cycle 12 for the A and B forms, cycle 20 for the indexed form and cycle 16 for the HL form. `busy` is high from the cycle after the last instruction byte up to and including the `done` cycle.
- R7: The indexed form addresses memory at {I, N, displacement}, with I in bits 23:16, N in bits 15:8 and the third instruction byte in bits 7:0.
- R8: The HL form addresses memory at {I, HL}, with I in bits 23:16 and HL in bits 15:0.
- R9: A memory form issues exactly one read, in the first busy cycle, and takes `mem_rdata` in the following cycle. It then issues exactly one write of the result to the same address, in the cycle before `done`.
- R10: Exactly one result strobe (`a_we`, `b_we` or `mem_we`, matching the form) is raised, together with `flags_we`, in the cycle before `done`. No strobe is raised at any other time.
- R11: Bytes presented while `busy` is high are ignored: they cause no extra reads, writes, flag updates or done pulses.
- R12: After 0xCE, any second byte outside 0x9C to 0x9F raises `illegal` for one cycle, in the cycle after that byte. It causes no register, memory or flag write, and the unit returns to idle.
- R13: A valid byte other than 0xCE presented while idle is discarded and causes no output activity.
- R14: While reset is asserted, and right after it, every strobe together with `busy`, `done` and `illegal` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Instruction byte on `op_byte` is valid this cycle |
| op_byte | input | 8 | Instruction byte stream (prefix, opcode, displacement) |
| reg_a | input | 8 | Current value of register A |
| reg_b | input | 8 | Current value of register B |
| reg_hl | input | 16 | Current value of register pair HL |
| reg_n | input | 8 | Current value of page register N |
| reg_i | input | 8 | Current value of bank register I |
| flags_in | input | 8 | Current flags register |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_re` |
| a_out | output | 8 | New value for register A |
| a_we | output | 1 | Write strobe for register A |
| b_out | output | 8 | New value for register B |
| b_we | output | 1 | Write strobe for register B |
| mem_addr | output | 24 | Memory byte address |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write request |
| mem_wdata | output | 8 | Memory write data |
| flags_out | output | 8 | New flags value |
| flags_we | output | 1 | Write strobe for the flags register |
| busy | output | 1 | Instruction executing; bytes ignored |
| done | output | 1 | One-cycle end-of-instruction pulse |
| illegal | output | 1 | One-cycle pulse for an unknown second opcode byte |

## Verification
A wrong cycle counter or a wrongly loaded count shows first as a write strobe and a `done` pulse in the wrong cycle of the instruction. The scoreboard tags every expected strobe with its absolute cycle, so an early or late event fails in that same cycle. A wrong decoder state shows as an unexpected strobe or a missing pulse within two cycles of the offending byte; a byte that is accepted while busy, for example, produces stray reads or writes before the running instruction ends. A corrupted operand or address register shows at the single write of the result, where the data, the address and the flags are compared together.

// File: rtl/rotr_pkg.sv
// Shared opcode values, flag bit positions and types for the rotate-right
// execution unit. Assumes an 8-bit datapath and 8-bit flags word.
package rotr_pkg;

    localparam int DATA_W = 8;
    localparam int FLAG_W = 8;

    // Opcode bytes of the rotate-right family
    localparam logic [DATA_W-1:0] OPC_PREFIX  = 8'hCE;
    localparam logic [DATA_W-1:0] OPC_ROT_A   = 8'h9C;
    localparam logic [DATA_W-1:0] OPC_ROT_B   = 8'h9D;
    localparam logic [DATA_W-1:0] OPC_ROT_IDX = 8'h9E;
    localparam logic [DATA_W-1:0] OPC_ROT_HL  = 8'h9F;

    // Flag bit positions updated by the unit; all others pass through
    localparam int FLG_ZERO  = 0;
    localparam int FLG_CARRY = 1;
    localparam int FLG_SIGN  = 3;

    typedef enum logic [1:0] {
        TGT_A   = 2'd0,
        TGT_B   = 2'd1,
        TGT_IDX = 2'd2,
        TGT_HL  = 2'd3
    } rot_target_e;

    typedef enum logic [1:0] {
        DEC_IDLE   = 2'd0,
        DEC_PREFIX = 2'd1,
        DEC_DISP   = 2'd2
    } dec_state_e;

endpackage

// File: rtl/rotr_decode.sv
// Instruction byte decoder for the rotate-right family.
// Consumes one byte per cycle when op_valid is high and the unit is idle.
// Raises start (combinational) in the cycle the final instruction byte is
// presented, with the selected target. An unknown second byte produces a
// registered illegal pulse one cycle later.
// Assumes: busy gates acceptance of bytes entirely.
module rotr_decode
    import rotr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              busy,
    output logic              start,
    output rot_target_e       start_tgt,
    output logic              illegal
);

    dec_state_e state_q, state_d;
    logic       accept;
    logic       bad_d;

    assign accept = byte_vld && !busy;

    // Next-state and start/illegal decode from the current byte
    always_comb begin
        state_d   = state_q;
        start     = 1'b0;
        start_tgt = TGT_A;
        bad_d     = 1'b0;
        case (state_q)
            DEC_IDLE: begin
                if (accept && byte_in == OPC_PREFIX) begin
                    state_d = DEC_PREFIX;
                end
            end
            DEC_PREFIX: begin
                if (accept) begin
                    state_d = DEC_IDLE;
                    case (byte_in)
                        OPC_ROT_A: begin
                            start     = 1'b1;
                            start_tgt = TGT_A;
                        end
                        OPC_ROT_B: begin
                            start     = 1'b1;
                            start_tgt = TGT_B;
                        end
                        OPC_ROT_HL: begin
                            start     = 1'b1;
                            start_tgt = TGT_HL;
                        end
                        OPC_ROT_IDX: begin
                            state_d = DEC_DISP;
                        end
                        default: begin
                            bad_d = 1'b1;
                        end
                    endcase
                end
            end
            DEC_DISP: begin
                if (accept) begin
                    start     = 1'b1;
                    start_tgt = TGT_IDX;
                    state_d   = DEC_IDLE;
                end
            end
            default: state_d = DEC_IDLE;
        endcase
    end

    // State register and registered illegal pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DEC_IDLE;
            illegal <= 1'b0;
        end else begin
            state_q <= state_d;
            illegal <= bad_d;
        end
    end

endmodule

// File: rtl/rotr_seq.sv
// Execution sequencer: a down-counter loaded at start that frames the
// busy window. Provides the first busy cycle (memory read), the second
// (read data capture), the write cycle (count 1) and done (count 0).
// Assumes: load value is at least 3 so capture precedes the write.
module rotr_seq #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load,
    output logic             busy,
    output logic             rd_cyc,
    output logic             cap_cyc,
    output logic             wr_cyc,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;
    logic             active_q;
    logic [1:0]       phase_q;

    // Counter, activity flag and early-phase marker bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
            phase_q  <= 2'b00;
        end else if (start && !active_q) begin
            cnt_q    <= load;
            active_q <= 1'b1;
            phase_q  <= 2'b01;
        end else if (active_q) begin
            phase_q <= {phase_q[0], 1'b0};
            if (cnt_q == '0) begin
                active_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // Cycle-role decode from the counter state
    always_comb begin
        busy    = active_q;
        rd_cyc  = active_q && phase_q[0];
        cap_cyc = active_q && phase_q[1];
        wr_cyc  = active_q && (cnt_q == CNT_W'(1));
        done    = active_q && (cnt_q == '0);
    end

endmodule

// File: rtl/rotr_alu.sv
// Rotate-right-by-one datapath with flag merge. Purely combinational.
// Zero, carry and sign are recomputed; every other flag bit passes through.
module rotr_alu
    import rotr_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [DW-1:0]     opnd,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [DW-1:0]     result,
    output logic [FLAG_W-1:0] flags_out
);

    // Each result bit takes the operand bit one place to its left, wrapping
    for (genvar gi = 0; gi < DW; gi++) begin : g_rot
        assign result[gi] = opnd[(gi + 1) % DW];
    end

    // Merge recomputed flags into the incoming flags word
    always_comb begin
        flags_out            = flags_in;
        flags_out[FLG_ZERO]  = (result == '0);
        flags_out[FLG_CARRY] = result[DW-1];
        flags_out[FLG_SIGN]  = result[DW-1];
    end

endmodule

// File: rtl/rotr_exec_unit.sv
// Rotate-right execution unit top. Decodes the byte stream, latches the
// operand or the bank-extended address, sequences the per-form cycle count
// and drives write-back, memory and flag strobes.
// Assumes: memory read data is valid the cycle after mem_re; register and
// flag inputs are stable while the unit is busy.
module rotr_exec_unit
    import rotr_pkg::*;
#(
    parameter int CYC_REG = 12,
    parameter int CYC_IDX = 20,
    parameter int CYC_HL  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [DATA_W-1:0]   op_byte,
    input  logic [DATA_W-1:0]   reg_a,
    input  logic [DATA_W-1:0]   reg_b,
    input  logic [2*DATA_W-1:0] reg_hl,
    input  logic [DATA_W-1:0]   reg_n,
    input  logic [DATA_W-1:0]   reg_i,
    input  logic [FLAG_W-1:0]   flags_in,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic [DATA_W-1:0]   a_out,
    output logic                a_we,
    output logic [DATA_W-1:0]   b_out,
    output logic                b_we,
    output logic [3*DATA_W-1:0] mem_addr,
    output logic                mem_re,
    output logic                mem_we,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic [FLAG_W-1:0]   flags_out,
    output logic                flags_we,
    output logic                busy,
    output logic                done,
    output logic                illegal
);

    localparam int ADDR_W  = 3 * DATA_W;
    localparam int CYC_MAX = (CYC_REG > CYC_IDX) ?
                             ((CYC_REG > CYC_HL) ? CYC_REG : CYC_HL) :
                             ((CYC_IDX > CYC_HL) ? CYC_IDX : CYC_HL);
    localparam int CNT_W   = $clog2(CYC_MAX + 1);
    // Counter loads: total minus instruction bytes minus the done cycle
    localparam logic [CNT_W-1:0] LOAD_REG = CNT_W'(CYC_REG - 3);
    localparam logic [CNT_W-1:0] LOAD_IDX = CNT_W'(CYC_IDX - 4);
    localparam logic [CNT_W-1:0] LOAD_HL  = CNT_W'(CYC_HL - 3);

    logic              start;
    rot_target_e       start_tgt;
    rot_target_e       tgt_q;
    logic [DATA_W-1:0] opnd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  load_val;
    logic              rd_cyc, cap_cyc, wr_cyc;
    logic              is_mem;
    logic [DATA_W-1:0] result;

    rotr_decode u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_vld  (op_valid),
        .byte_in   (op_byte),
        .busy      (busy),
        .start     (start),
        .start_tgt (start_tgt),
        .illegal   (illegal)
    );

    // Pick the counter load for the form being started
    always_comb begin
        case (start_tgt)
            TGT_IDX: load_val = LOAD_IDX;
            TGT_HL:  load_val = LOAD_HL;
            default: load_val = LOAD_REG;
        endcase
    end

    rotr_seq #(
        .CNT_W (CNT_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .load    (load_val),
        .busy    (busy),
        .rd_cyc  (rd_cyc),
        .cap_cyc (cap_cyc),
        .wr_cyc  (wr_cyc),
        .done    (done)
    );

    // Latch target, register operand or memory address; capture read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q  <= TGT_A;
            opnd_q <= '0;
            addr_q <= '0;
        end else if (start && !busy) begin
            tgt_q <= start_tgt;
            case (start_tgt)
                TGT_A:   opnd_q <= reg_a;
                TGT_B:   opnd_q <= reg_b;
                TGT_IDX: addr_q <= {reg_i, reg_n, op_byte};
                default: addr_q <= {reg_i, reg_hl};
            endcase
        end else if (cap_cyc && is_mem) begin
            opnd_q <= mem_rdata;
        end
    end

    assign is_mem = (tgt_q == TGT_IDX) || (tgt_q == TGT_HL);

    rotr_alu #(
        .DW (DATA_W)
    ) u_alu (
        .opnd      (opnd_q),
        .flags_in  (flags_in),
        .result    (result),
        .flags_out (flags_out)
    );

    // Drive write-back, memory and flag strobes from the sequencer roles
    always_comb begin
        a_out     = result;
        b_out     = result;
        mem_wdata = result;
        mem_addr  = addr_q;
        a_we      = wr_cyc && (tgt_q == TGT_A);
        b_we      = wr_cyc && (tgt_q == TGT_B);
        mem_we    = wr_cyc && is_mem;
        mem_re    = rd_cyc && is_mem;
        flags_we  = wr_cyc;
    end

endmodule

// File: rtl/rotr_exec_unit_chk.sv
// Property checker for the rotate-right execution unit, bound to the top.
// Observes ports only, plus a local record of the last read address.
module rotr_exec_unit_chk
    import rotr_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [FLAG_W-1:0]   flags_in,
    input logic [DATA_W-1:0]   a_out,
    input logic                a_we,
    input logic                b_we,
    input logic [3*DATA_W-1:0] mem_addr,
    input logic                mem_re,
    input logic                mem_we,
    input logic [FLAG_W-1:0]   flags_out,
    input logic                flags_we,
    input logic                busy,
    input logic                done,
    input logic                illegal
);

    localparam logic [FLAG_W-1:0] KEEP_MASK =
        ~((FLAG_W'(1) << FLG_ZERO) | (FLAG_W'(1) << FLG_CARRY) | (FLAG_W'(1) << FLG_SIGN));

    logic [3*DATA_W-1:0] last_rd_q;
    logic                rd_seen_q;

    // Remember the address of the read of the current instruction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_rd_q <= '0;
            rd_seen_q <= 1'b0;
        end else if (mem_re) begin
            last_rd_q <= mem_addr;
            rd_seen_q <= 1'b1;
        end else if (done) begin
            rd_seen_q <= 1'b0;
        end
    end

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_idle_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    p_done_inside_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    p_write_before_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(flags_we));
    p_strobes_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (a_we || b_we || mem_we || flags_we) |-> (busy && !done));
    p_one_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({a_we, b_we, mem_we}));
    p_no_rw_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));
    p_write_same_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (rd_seen_q && mem_addr == last_rd_q));
    p_zero_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we |-> (flags_out[FLG_ZERO] == (a_out == '0)));
    p_carry_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we |-> (flags_out[FLG_CARRY] == a_out[DATA_W-1] &&
                      flags_out[FLG_SIGN] == a_out[DATA_W-1]));
    p_keep_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we |-> (((flags_out ^ flags_in) & KEEP_MASK) == '0));
    p_illegal_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!busy && !flags_we && !mem_re));

endmodule

bind rotr_exec_unit rotr_exec_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flags_in  (flags_in),
    .a_out     (a_out),
    .a_we      (a_we),
    .b_we      (b_we),
    .mem_addr  (mem_addr),
    .mem_re    (mem_re),
    .mem_we    (mem_we),
    .flags_out (flags_out),
    .flags_we  (flags_we),
    .busy      (busy),
    .done      (done),
    .illegal   (illegal)
);

// File: tb/rotr_exec_unit_test.sv
// Scoreboard bench: driver tasks queue expected events tagged with their
// cycle; a monitor pops and compares them as the unit produces them.
module rotr_exec_unit_test;
    import rotr_pkg::*;

    localparam int K_RD = 0, K_ILL = 1, K_A = 2, K_B = 3, K_MEM = 4, K_FLG = 5, K_DONE = 6;

    typedef struct {
        int          kind;
        logic [7:0]  data;
        logic [23:0] addr;
        int          cyc;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    int   cyc    = 0;
    bit   finished = 0;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [7:0]  op_byte;
    logic [7:0]  reg_a, reg_b, reg_n, reg_i, flags_in, mem_rdata;
    logic [15:0] reg_hl;
    logic [7:0]  a_out, b_out, mem_wdata, flags_out;
    logic        a_we, b_we, mem_re, mem_we, flags_we, busy, done, illegal;
    logic [23:0] mem_addr;
    logic [7:0]  mem_img;

    always #10 clk = ~clk;  // 50 MHz

    always @(posedge clk) cyc <= cyc + 1;

    // Memory model: one cycle read latency
    always @(posedge clk) begin
        if (mem_re) mem_rdata <= mem_img;
    end

    rotr_exec_unit uut (
        .clk (clk), .rst_n (rst_n), .op_valid (op_valid), .op_byte (op_byte),
        .reg_a (reg_a), .reg_b (reg_b), .reg_hl (reg_hl), .reg_n (reg_n),
        .reg_i (reg_i), .flags_in (flags_in), .mem_rdata (mem_rdata),
        .a_out (a_out), .a_we (a_we), .b_out (b_out), .b_we (b_we),
        .mem_addr (mem_addr), .mem_re (mem_re), .mem_we (mem_we),
        .mem_wdata (mem_wdata), .flags_out (flags_out), .flags_we (flags_we),
        .busy (busy), .done (done), .illegal (illegal)
    );

    task automatic push_exp(input int kind, input logic [7:0] d, input logic [23:0] a,
                            input int c, input string tag);
        exp_t e;
        e.kind = kind; e.data = d; e.addr = a; e.cyc = c; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic observe(input int kind, input logic [7:0] d, input logic [23:0] a);
        exp_t e;
        checks++;
        if (q.size() == 0) begin
            errors++;
            $display("FAIL R11 unexpected event kind %0d data %02h addr %06h cycle %0d, expected none",
                     kind, d, a, cyc);
        end else begin
            e = q.pop_front();
            if (e.kind != kind || e.data !== d || e.addr !== a || e.cyc != cyc) begin
                errors++;
                $display("FAIL %s actual kind %0d data %02h addr %06h cycle %0d expected kind %0d data %02h addr %06h cycle %0d",
                         e.tag, kind, d, a, cyc, e.kind, e.data, e.addr, e.cyc);
            end
        end
    endtask

    // Monitor: compare every output event against the queue head
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !finished) begin
            if (mem_re)   observe(K_RD, 8'h00, mem_addr);
            if (illegal)  observe(K_ILL, 8'h00, 24'h0);
            if (a_we)     observe(K_A, a_out, 24'h0);
            if (b_we)     observe(K_B, b_out, 24'h0);
            if (mem_we)   observe(K_MEM, mem_wdata, mem_addr);
            if (flags_we) observe(K_FLG, flags_out, 24'h0);
            if (done)     observe(K_DONE, 8'h00, 24'h0);
        end
    end

    function automatic logic [7:0] exp_flags(input logic [7:0] res, input logic [7:0] fin);
        logic [7:0] f;
        f    = fin;
        f[0] = (res == 8'h00);  // R3 zero
        f[1] = res[7];          // R4 carry
        f[3] = res[7];          // R4 sign
        return f;
    endfunction

    // Driver: run one instruction of form tgt (0 A, 1 B, 2 indexed, 3 HL)
    task automatic run_op(input int tgt, input logic [7:0] val, input logic [7:0] disp,
                          input logic [7:0] fin, input bit spam, input string tag);
        int          c0, n, k;
        logic [7:0]  res;
        logic [23:0] addr;
        logic [7:0]  op2;
        int          wk;
        n   = (tgt == 2) ? 20 : (tgt == 3) ? 16 : 12;  // R6 counts
        k   = (tgt == 2) ? 3 : 2;
        op2 = (tgt == 0) ? 8'h9C : (tgt == 1) ? 8'h9D : (tgt == 2) ? 8'h9E : 8'h9F;
        res = {val[0], val[7:1]};                      // R2 rotation
        addr = (tgt == 2) ? {reg_i, reg_n, disp} : {reg_i, reg_hl};  // R7 / R8
        wk  = (tgt == 0) ? K_A : (tgt == 1) ? K_B : K_MEM;
        if (tgt == 0) reg_a = val;
        if (tgt == 1) reg_b = val;
        if (tgt >= 2) mem_img = val;
        flags_in = fin;
        @(negedge clk);
        c0 = cyc;
        if (tgt >= 2) push_exp(K_RD, 8'h00, addr, c0 + k, {tag, " R9 read"});
        push_exp(wk, res, (tgt >= 2) ? addr : 24'h0, c0 + n - 2, {tag, " R2 R10 result"});
        push_exp(K_FLG, exp_flags(res, fin), 24'h0, c0 + n - 2, {tag, " R3 R4 R5 flags"});
        push_exp(K_DONE, 8'h00, 24'h0, c0 + n - 1, {tag, " R6 done"});
        op_valid = 1'b1;
        op_byte  = 8'hCE;
        @(negedge clk);
        op_byte = op2;
        if (tgt == 2) begin
            @(negedge clk);
            op_byte = disp;
        end
        @(negedge clk);
        if (spam) begin
            // R11: keep offering bytes during the busy window
            for (int i = 0; cyc <= c0 + n - 1; i++) begin
                op_byte = (i % 2 == 0) ? 8'hCE : 8'h9D;
                @(negedge clk);
            end
        end
        op_valid = 1'b0;
        while (cyc < c0 + n + 1) @(negedge clk);
    endtask

    // Driver: prefix followed by an unknown second byte (R12)
    task automatic run_illegal(input logic [7:0] op2);
        int c0;
        @(negedge clk);
        c0 = cyc;
        push_exp(K_ILL, 8'h00, 24'h0, c0 + 2, "R12 illegal pulse");
        op_valid = 1'b1;
        op_byte  = 8'hCE;
        @(negedge clk);
        op_byte = op2;
        @(negedge clk);
        op_valid = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; op_valid = 1'b0; op_byte = 8'h00;
        reg_a = 8'h00; reg_b = 8'h00; reg_hl = 16'h0000; reg_n = 8'h00; reg_i = 8'h00;
        flags_in = 8'h00; mem_rdata = 8'h00; mem_img = 8'h00;
        repeat (3) @(negedge clk);
        // R14: quiet outputs while in reset
        checks++;
        if ({a_we, b_we, mem_re, mem_we, flags_we, busy, done, illegal} !== 8'h00) begin
            errors++;
            $display("FAIL R14 strobes in reset actual %08b expected 00000000",
                     {a_we, b_we, mem_re, mem_we, flags_we, busy, done, illegal});
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if ({a_we, b_we, mem_re, mem_we, flags_we, busy, done, illegal} !== 8'h00) begin
            errors++;
            $display("FAIL R14 strobes after reset actual %08b expected 00000000",
                     {a_we, b_we, mem_re, mem_we, flags_we, busy, done, illegal});
        end

        run_op(0, 8'h04, 8'h00, 8'h00, 1'b0, "R1 A 04");
        run_op(1, 8'h45, 8'h00, 8'h00, 1'b0, "R1 B 45");
        run_op(1, 8'h84, 8'h00, 8'h00, 1'b0, "R1 B 84");
        reg_i = 8'h12; reg_hl = 16'h3456;
        run_op(3, 8'h01, 8'h00, 8'h00, 1'b0, "R8 HL 01");
        reg_i = 8'hAB; reg_n = 8'hCD;
        run_op(2, 8'h00, 8'h0F, 8'h00, 1'b0, "R7 IDX 00");
        run_op(2, 8'h81, 8'hF0, 8'hF7, 1'b0, "R7 IDX 81");
        run_op(0, 8'h01, 8'h00, 8'hFF, 1'b0, "R5 A 01");
        run_op(0, 8'hFE, 8'h00, 8'h04, 1'b1, "R11 A FE busy bytes");
        run_op(3, 8'h55, 8'h00, 8'h2A, 1'b1, "R11 HL 55 busy bytes");
        run_illegal(8'h9B);
        run_illegal(8'hCE);
        // R13: lone opcode bytes without prefix are discarded
        @(negedge clk);
        op_valid = 1'b1; op_byte = 8'h9C;
        @(negedge clk);
        op_byte = 8'h9E;
        @(negedge clk);
        op_valid = 1'b0;
        repeat (14) @(negedge clk);
        run_op(1, 8'h00, 8'h00, 8'h00, 1'b0, "R13 B 00 after strays");

        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R6 pending expected events actual %0d expected 0", q.size());
        end
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL R6 watchdog actual cycle %0d expected completion before 20000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule